// File: doc/BRIEF.md
# Monitor Channel Byte Receiver

This block is the receive side of a frame-slotted control channel. In every frame time slot the sender supplies one already-deserialized byte and an active-low "byte present" flag (E). The receiver accepts a byte only after it has seen the same value in two consecutive frames. It answers on an active-low acknowledge line (A) with a fixed handshake pattern, and it hands each accepted byte to a downstream consumer as a one-clock pulse.

A message opens in the frame where E goes from high to low, and that frame already carries the first byte. After the first byte has been accepted, A stays low. Every later byte is announced by E going high for exactly one frame. The receiver then answers with a one-frame high on A (pre-acknowledge) followed by A low again (acknowledge). E high for two frames in a row closes the message. A byte that fails the double-reception check aborts the message. The abort signal depends on where the check failed: after the first byte, A goes low for a single frame; after a later byte, A stays high past the pre-acknowledge. In both cases the consumer sees an abort pulse, and the partial message is discarded.

Top module: `mon_byte_rx`

## Requirements
- R1: Out of reset and between messages, `a_n` is 1 (inactive) and `out_valid`, `out_som`, `out_eom` and `out_abort` are 0.
- R2: A message starts only in a frame where `e_n` is 0 and `e_n` was 1 in the previous frame. When `e_n` stays 0 without a preceding 1, nothing starts and `a_n` stays 1.
- R3: If the frame after the start frame has `e_n` = 0 and the same byte, that byte is delivered with `out_valid` = 1 and `out_som` = 1, and `a_n` becomes 0 in the same update.
- R4: While the sender keeps `e_n` at 0 after a byte has been acknowledged, `a_n` stays 0 and nothing is delivered.
- R5: If the first byte differs between its two frames, or `e_n` is 1 in the second frame, `out_abort` pulses and `a_n` is 0 for exactly that one frame, then returns to 1.
- R6: A later byte is framed as one frame with `e_n` = 1 followed by a frame with `e_n` = 0 carrying the same byte. The byte is then delivered with `out_som` = 0, and `a_n` is 1 for that frame (pre-acknowledge) and 0 in the next frame (acknowledge).
- R7: If a later byte differs between its two frames, `a_n` is 1 for that frame and stays 1 in the next frame. `out_abort` pulses, no further byte of that message is delivered, and the receiver returns to idle.
- R8: When `e_n` is 1 in two consecutive frames during a message, `out_eom` pulses on the second of them and `a_n` returns to 1.
- R9: Every output update follows a `frame_stb` by one clock. The pulses `out_valid`, `out_eom` and `out_abort` last one clock, at most one of them is high at a time, and `a_n` changes only in the clock after a strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| frame_stb | input | 1 | One-clock pulse marking the monitor time slot of a frame |
| mon_byte | input | BYTE_W | Monitor byte received in this frame |
| e_n | input | 1 | Active-low byte-present flag from the sender |
| a_n | output | 1 | Active-low acknowledge to the sender |
| out_valid | output | 1 | One-clock pulse: validated byte on `out_byte` |
| out_byte | output | BYTE_W | Validated byte |
| out_som | output | 1 | With `out_valid`: first byte of a message |
| out_eom | output | 1 | One-clock pulse: message ended normally |
| out_abort | output | 1 | One-clock pulse: message aborted, partial data void |

## Verification
The embedded assertions check the following properties on every clock:
- the start-of-message flag always coincides with a delivered byte and with A low;
- a later byte always coincides with the pre-acknowledge level on A;
- the end pulse always sees A released;
- the three pulses are mutually exclusive;
- A moves only right after a strobe.

Other behaviour spans several frames and is shown only by the bench's scenarios:
- the one-frame low A on a first-byte abort;
- the held-high A on a later-byte abort;
- the refusal to start without a high-to-low edge on E;
- the correct byte stream in random messages with random repeats and corruptions.

// File: rtl/mon_rx_pkg.sv
package mon_rx_pkg;

  typedef enum logic [2:0] {
    RX_IDLE  = 3'd0,  // waiting for E high-to-low
    RX_CHK1  = 3'd1,  // second frame of the first byte
    RX_ACK   = 3'd2,  // byte acknowledged, A low
    RX_GAP   = 3'd3,  // E was high for one frame
    RX_PACK  = 3'd4,  // pre-acknowledge sent, acknowledge next
    RX_PABT  = 3'd5,  // pre-acknowledge sent, abort next
    RX_ABRT  = 3'd6   // single-frame A pulse sent, release next
  } rx_state_e;

endpackage

// File: rtl/mon_rst_sync.sv
module mon_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_n_sync = chain_q[STAGES-1];

endmodule

// File: rtl/mon_rx_sampler.sv
module mon_rx_sampler #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_stb,
  input  logic [BYTE_W-1:0] mon_byte,
  input  logic              e_n,
  output logic              prev_e_n,
  output logic              same_byte
);

  logic [BYTE_W-1:0] last_byte_q, last_byte_d;
  logic              last_e_q, last_e_d;

  always_comb begin
    last_byte_d = last_byte_q;
    last_e_d    = last_e_q;
    if (frame_stb) begin
      last_byte_d = mon_byte;
      last_e_d    = e_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_byte_q <= '0;
      last_e_q    <= 1'b1;
    end else begin
      last_byte_q <= last_byte_d;
      last_e_q    <= last_e_d;
    end
  end

  assign prev_e_n  = last_e_q;
  assign same_byte = (mon_byte == last_byte_q);

endmodule

// File: rtl/mon_rx_fsm.sv
module mon_rx_fsm
  import mon_rx_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_stb,
  input  logic [BYTE_W-1:0] mon_byte,
  input  logic              e_n,
  input  logic              prev_e_n,
  input  logic              same_byte,
  output logic              a_n,
  output logic              out_valid,
  output logic [BYTE_W-1:0] out_byte,
  output logic              out_som,
  output logic              out_eom,
  output logic              out_abort
);

  rx_state_e         state_q, state_d;
  logic              a_q, a_d;
  logic              vld_q, vld_d;
  logic              som_q, som_d;
  logic              eom_q, eom_d;
  logic              abt_q, abt_d;
  logic [BYTE_W-1:0] byte_q, byte_d;

  always_comb begin
    state_d = state_q;
    a_d     = a_q;
    byte_d  = byte_q;
    vld_d   = 1'b0;
    som_d   = 1'b0;
    eom_d   = 1'b0;
    abt_d   = 1'b0;
    if (frame_stb) begin
      unique case (state_q)
        RX_IDLE: begin
          a_d = 1'b1;
          if (!e_n && prev_e_n) state_d = RX_CHK1;
        end
        RX_CHK1: begin
          a_d = 1'b0;
          if (!e_n && same_byte) begin
            vld_d   = 1'b1;
            som_d   = 1'b1;
            byte_d  = mon_byte;
            state_d = RX_ACK;
          end else begin
            abt_d   = 1'b1;
            state_d = RX_ABRT;
          end
        end
        RX_ACK, RX_PACK: begin
          a_d     = 1'b0;
          state_d = e_n ? RX_GAP : RX_ACK;
        end
        RX_GAP: begin
          if (e_n) begin
            a_d     = 1'b1;
            eom_d   = 1'b1;
            state_d = RX_IDLE;
          end else if (same_byte) begin
            a_d     = 1'b1;
            vld_d   = 1'b1;
            byte_d  = mon_byte;
            state_d = RX_PACK;
          end else begin
            a_d     = 1'b1;
            abt_d   = 1'b1;
            state_d = RX_PABT;
          end
        end
        RX_PABT, RX_ABRT: begin
          a_d     = 1'b1;
          state_d = RX_IDLE;
        end
        default: begin
          a_d     = 1'b1;
          state_d = RX_IDLE;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RX_IDLE;
      a_q     <= 1'b1;
      vld_q   <= 1'b0;
      som_q   <= 1'b0;
      eom_q   <= 1'b0;
      abt_q   <= 1'b0;
      byte_q  <= '0;
    end else begin
      state_q <= state_d;
      a_q     <= a_d;
      vld_q   <= vld_d;
      som_q   <= som_d;
      eom_q   <= eom_d;
      abt_q   <= abt_d;
      byte_q  <= byte_d;
    end
  end

  assign a_n       = a_q;
  assign out_valid = vld_q;
  assign out_byte  = byte_q;
  assign out_som   = som_q;
  assign out_eom   = eom_q;
  assign out_abort = abt_q;

  // R3: the first byte always comes with A active
  assert_som_ack_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_som |-> (out_valid && !a_n));

  // R6: a later byte is delivered while A shows the pre-acknowledge level
  assert_preack_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_som) |-> a_n);

  // R8: A is released when the message ends
  assert_eom_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_eom |-> a_n);

  // R9: the consumer pulses exclude each other
  assert_pulse_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({out_valid, out_eom, out_abort}));

  // R9: A moves only in the clock after a strobe
  assert_a_frame_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(frame_stb) |-> $stable(a_n));

endmodule

// File: rtl/mon_byte_rx.sv
module mon_byte_rx #(
  parameter int BYTE_W     = 8,
  parameter int SYNC_DEPTH = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_stb,
  input  logic [BYTE_W-1:0] mon_byte,
  input  logic              e_n,
  output logic              a_n,
  output logic              out_valid,
  output logic [BYTE_W-1:0] out_byte,
  output logic              out_som,
  output logic              out_eom,
  output logic              out_abort
);

  logic rst_n_int;
  logic prev_e_n;
  logic same_byte;

  mon_rst_sync #(.STAGES(SYNC_DEPTH)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  mon_rx_sampler #(.BYTE_W(BYTE_W)) u_smp (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .frame_stb (frame_stb),
    .mon_byte  (mon_byte),
    .e_n       (e_n),
    .prev_e_n  (prev_e_n),
    .same_byte (same_byte)
  );

  mon_rx_fsm #(.BYTE_W(BYTE_W)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .frame_stb (frame_stb),
    .mon_byte  (mon_byte),
    .e_n       (e_n),
    .prev_e_n  (prev_e_n),
    .same_byte (same_byte),
    .a_n       (a_n),
    .out_valid (out_valid),
    .out_byte  (out_byte),
    .out_som   (out_som),
    .out_eom   (out_eom),
    .out_abort (out_abort)
  );

endmodule

// File: tb/tb_mon_byte_rx.sv
module tb_mon_byte_rx;

  logic       clk;
  logic       rst_n;
  logic       frame_stb;
  logic [7:0] mon_byte;
  logic       e_n;
  logic       a_n;
  logic       out_valid;
  logic [7:0] out_byte;
  logic       out_som;
  logic       out_eom;
  logic       out_abort;

  int checks;
  int errors;
  bit done;

  mon_byte_rx dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .frame_stb (frame_stb),
    .mon_byte  (mon_byte),
    .e_n       (e_n),
    .a_n       (a_n),
    .out_valid (out_valid),
    .out_byte  (out_byte),
    .out_som   (out_som),
    .out_eom   (out_eom),
    .out_abort (out_abort)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [12:0] pack_exp(input logic a, input logic v, input logic s,
                                           input logic [7:0] b, input logic eo,
                                           input logic ab);
    return {a, v, s, eo, ab, (v ? b : 8'h00)};
  endfunction

  function automatic logic [7:0] flip_bit(input logic [7:0] b);
    return b ^ (8'h01 << ($urandom % 8));
  endfunction

  task automatic check(input logic [12:0] act, input logic [12:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual a/v/som/eom/abt/byte=%b expected %b", req, act, exp);
    end
  endtask

  // one frame: drive slot, sample the update, then confirm pulses drop (R9)
  task automatic frame(input logic e, input logic [7:0] b, input logic ea, input logic ev,
                       input logic es, input logic [7:0] eb, input logic ee,
                       input logic eab, input string req);
    @(negedge clk);
    e_n = e; mon_byte = b; frame_stb = 1'b1;
    @(negedge clk);
    frame_stb = 1'b0;
    check({a_n, out_valid, out_som, out_eom, out_abort, (out_valid ? out_byte : 8'h00)},
          pack_exp(ea, ev, es, eb, ee, eab), req);
    @(negedge clk);
    check({a_n, out_valid, out_som, out_eom, out_abort, 8'h00},
          pack_exp(ea, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0), "R9");
    @(negedge clk);
  endtask

  // well-formed sender; bad = index of byte whose second copy is corrupted, -1 none
  task automatic send_msg(input int n, input int bad);
    logic [7:0] m [8];
    for (int i = 0; i < 8; i++) m[i] = 8'($urandom);
    frame(1'b0, m[0], 1'b1, 0, 0, 8'h00, 0, 0, "R2");
    if (bad == 0) begin
      frame(1'b0, flip_bit(m[0]), 1'b0, 0, 0, 8'h00, 0, 1, "R5");
      frame(1'b1, 8'hff, 1'b1, 0, 0, 8'h00, 0, 0, "R5");
      return;
    end
    frame(1'b0, m[0], 1'b0, 1, 1, m[0], 0, 0, "R3");
    if ($urandom % 2 == 0) frame(1'b0, m[0], 1'b0, 0, 0, 8'h00, 0, 0, "R4");
    for (int i = 1; i < n; i++) begin
      frame(1'b1, m[i], 1'b0, 0, 0, 8'h00, 0, 0, "R6");
      if (bad == i) begin
        frame(1'b0, flip_bit(m[i]), 1'b1, 0, 0, 8'h00, 0, 1, "R7");
        frame(1'b1, 8'hff, 1'b1, 0, 0, 8'h00, 0, 0, "R7");
        frame(1'b1, 8'hff, 1'b1, 0, 0, 8'h00, 0, 0, "R7");
        return;
      end
      frame(1'b0, m[i], 1'b1, 1, 0, m[i], 0, 0, "R6");
      if ($urandom % 2 == 0) frame(1'b0, m[i], 1'b0, 0, 0, 8'h00, 0, 0, "R6");
    end
    frame(1'b1, 8'hff, 1'b0, 0, 0, 8'h00, 0, 0, "R8");
    frame(1'b1, 8'hff, 1'b1, 0, 0, 8'h00, 1, 0, "R8");
    frame(1'b1, 8'hff, 1'b1, 0, 0, 8'h00, 0, 0, "R1");
  endtask

  initial begin
    void'($urandom(32'd1357));
    frame_stb = 1'b0; mon_byte = 8'h00; e_n = 1'b1; rst_n = 1'b0;
    checks = 0; errors = 0; done = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check({a_n, out_valid, out_som, out_eom, out_abort, 8'h00},
          pack_exp(1'b1, 0, 0, 8'h00, 0, 0), "R1");
    frame(1'b1, 8'h5a, 1'b1, 0, 0, 8'h00, 0, 0, "R1");

    // directed: single-byte and multi-byte messages
    send_msg(1, -1);
    send_msg(3, -1);
    // directed: first-byte and later-byte corruption
    send_msg(2, 0);
    send_msg(4, 2);

    // directed R5: E released in the second frame of the first byte
    frame(1'b0, 8'h3c, 1'b1, 0, 0, 8'h00, 0, 0, "R2");
    frame(1'b1, 8'h3c, 1'b0, 0, 0, 8'h00, 0, 1, "R5");
    frame(1'b1, 8'hff, 1'b1, 0, 0, 8'h00, 0, 0, "R5");

    // directed R2: E held low after an abort must not restart a message
    frame(1'b0, 8'h11, 1'b1, 0, 0, 8'h00, 0, 0, "R2");
    frame(1'b0, 8'h12, 1'b0, 0, 0, 8'h00, 0, 1, "R5");
    frame(1'b0, 8'h13, 1'b1, 0, 0, 8'h00, 0, 0, "R5");
    frame(1'b0, 8'h13, 1'b1, 0, 0, 8'h00, 0, 0, "R2");
    frame(1'b0, 8'h13, 1'b1, 0, 0, 8'h00, 0, 0, "R2");
    frame(1'b1, 8'hff, 1'b1, 0, 0, 8'h00, 0, 0, "R2");
    frame(1'b0, 8'h77, 1'b1, 0, 0, 8'h00, 0, 0, "R2");
    frame(1'b0, 8'h77, 1'b0, 1, 1, 8'h77, 0, 0, "R3");
    frame(1'b1, 8'hff, 1'b0, 0, 0, 8'h00, 0, 0, "R8");
    frame(1'b1, 8'hff, 1'b1, 0, 0, 8'h00, 1, 0, "R8");

    // random messages
    for (int k = 0; k < 60; k++) begin
      int n;
      int bad;
      n   = 1 + int'($urandom % 6);
      bad = ($urandom % 4 == 0) ? int'($urandom % n) : -1;
      send_msg(n, bad);
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule